// File: doc/BRIEF.md
# Multiplexed Grid Scan Timer

This block drives the grid (digit) electrodes of a multiplexed dot-matrix vacuum fluorescent display. It divides the oscillator clock into a base time unit of eight clock periods and splits each frame into a fixed number of equal digit slots. In each slot it drives exactly one grid, in ascending order from the first grid. The grid stays on for a programmable part of the slot, and the slot ends in a blank gap.

Two settings come from a command decoder through write strobes. The first is a 3-bit brightness code that sets the grid-on part of a slot. The second is a 4-bit digit-count code that sets how many grids take part in the scan. The block also gives the segment path the index of the current slot and a display-enable flag, so that segment data can be fetched and gated in step with the grid. Each new setting is held until the frame ends, so a frame never mixes two settings.

Top module: `grid_scan_top`

## Requirements
- R1: The slot position advances by one time unit T every 8 clock cycles (`TICK_DIV`), counted from the release of reset. With brightness code 0, grid 0 is on at cycles 0 through 255 after release and off at cycle 256.
- R2: A slot lasts 64 T. Grids are scanned in ascending order from grid 0, which is bit 0 of `grid_o`. `digit_idx_o` holds the current slot number.
- R3: For brightness code D (`duty_val`, 0..7), the grid is on for the first (8+D)*4 T of its slot and off for the rest of the slot. Code 0 gives 32 T and code 7 gives 60 T.
- R4: Digit-count code K (`digits_val`) enables grids 0..23 when K=0, and grids 0..K+7 (K+8 digits) when K is 1..15. Slots beyond the enabled count keep every grid off and `disp_en_o` low.
- R5: A frame always spans 24 slots (1536 T = 12288 cycles), whatever the digit count. The last slot ends at cycle 12287 of the frame, and grid 0 lights at cycle 12288.
- R6: At most one bit of `grid_o` is high at any time. `disp_en_o` is high exactly when a grid is on.
- R7: Synchronous reset sets the brightness code to 0 and the digit code to 0 (24 digits), restarts the scan at slot 0, T 0, and discards any setting written but not yet applied.
- R8: A value written through `duty_we`/`digits_we` takes effect at the next frame start. The rest of the current frame keeps the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_we | input | 1 | Write strobe for the brightness code |
| duty_val | input | 3 | Brightness code D |
| digits_we | input | 1 | Write strobe for the digit-count code |
| digits_val | input | 4 | Digit-count code K |
| grid_o | output | 24 | One-hot grid drive, bit n is grid n |
| digit_idx_o | output | 5 | Current slot index for the segment path |
| disp_en_o | output | 1 | High while the current grid is on |

## Verification
The assertions assume that the write strobes and their data are synchronous to `clk` and that reset is held for at least one edge before the scan is observed. The timing properties also assume that no write strobe falls on the final cycle of a frame. The bench drives every write at a falling edge. It only writes well inside a frame, never in the last slot's final cycles, so each write lands in a known frame. It then samples at computed cycle offsets from the release of reset.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;

    localparam int DUTY_W  = 3;
    localparam int DIGC_W  = 4;
    localparam int SLOT_TW = 6;
    localparam logic [SLOT_TW-1:0] SLOT_LAST = '1;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic [DIGC_W-1:0] digits;
    } scan_cfg_t;

    localparam scan_cfg_t CFG_RESET = '{duty: '0, digits: '0};

    // grid-on length in T units: (8 + D) * 4
    function automatic logic [SLOT_TW-1:0] on_ticks(input logic [DUTY_W-1:0] d);
        return SLOT_TW'((8 + int'(d)) * 4);
    endfunction

    // number of scanned grids for digit code k
    function automatic int active_grids(input logic [DIGC_W-1:0] k,
                                       input int base, input int maxg);
        return (k == '0) ? maxg : base + int'(k);
    endfunction

endpackage

// File: rtl/grid_tick_gen.sv
module grid_tick_gen #(
    parameter int TICK_DIV = 8,
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)          div_q <= '0;
        else if (tick_o)  div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == CW'(TICK_DIV - 1));

endmodule

// File: rtl/grid_slot_timer.sv
module grid_slot_timer
    import grid_scan_pkg::*;
#(
    parameter int NUM_GRIDS = 24,
    localparam int IDX_W = $clog2(NUM_GRIDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    output logic [IDX_W-1:0]   slot_o,
    output logic [SLOT_TW-1:0] t_o,
    output logic               frame_end_o
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_GRIDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_o <= '0;
            t_o    <= '0;
        end else if (tick_i) begin
            if (t_o == SLOT_LAST) begin
                t_o    <= '0;
                slot_o <= (slot_o == LAST_SLOT) ? '0 : slot_o + 1'b1;
            end else begin
                t_o <= t_o + 1'b1;
            end
        end
    end

    assign frame_end_o = tick_i && (t_o == SLOT_LAST) && (slot_o == LAST_SLOT);

    // R1
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(t_o) && $stable(slot_o)));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && t_o == SLOT_LAST && slot_o != LAST_SLOT)
            |=> (t_o == '0 && slot_o == IDX_W'($past(slot_o) + 1'b1)));

    // R5
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> (slot_o == '0 && t_o == '0));

endmodule

// File: rtl/grid_cfg_regs.sv
module grid_cfg_regs
    import grid_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              duty_we,
    input  logic [DUTY_W-1:0] duty_val,
    input  logic              digits_we,
    input  logic [DIGC_W-1:0] digits_val,
    input  logic              frame_end_i,
    output scan_cfg_t         act_o
);
    scan_cfg_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CFG_RESET;
        end else begin
            if (duty_we)   pend_q.duty   <= duty_val;
            if (digits_we) pend_q.digits <= digits_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              act_o <= CFG_RESET;
        else if (frame_end_i) act_o <= pend_q;
    end

    // R8
    cfg_frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end_i |=> $stable(act_o));

    // R7
    cfg_reset_val_chk: assert property (@(posedge clk)
        rst |=> (act_o == CFG_RESET));

endmodule

// File: rtl/grid_scan_top.sv
module grid_scan_top
    import grid_scan_pkg::*;
#(
    parameter int TICK_DIV   = 8,
    parameter int NUM_GRIDS  = 24,
    parameter int DIGIT_BASE = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         duty_we,
    input  logic [2:0]                   duty_val,
    input  logic                         digits_we,
    input  logic [3:0]                   digits_val,
    output logic [NUM_GRIDS-1:0]         grid_o,
    output logic [$clog2(NUM_GRIDS)-1:0] digit_idx_o,
    output logic                         disp_en_o
);
    localparam int IDX_W = $clog2(NUM_GRIDS);

    logic               tick;
    logic [IDX_W-1:0]   slot;
    logic [SLOT_TW-1:0] t_pos;
    logic               frame_end;
    scan_cfg_t          cfg;
    logic [IDX_W:0]     n_act;
    logic [SLOT_TW-1:0] on_len;
    logic               lit;

    grid_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    grid_slot_timer #(.NUM_GRIDS(NUM_GRIDS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .slot_o      (slot),
        .t_o         (t_pos),
        .frame_end_o (frame_end)
    );

    grid_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .duty_we     (duty_we),
        .duty_val    (duty_val),
        .digits_we   (digits_we),
        .digits_val  (digits_val),
        .frame_end_i (frame_end),
        .act_o       (cfg)
    );

    always_comb begin
        n_act  = (IDX_W+1)'(active_grids(cfg.digits, DIGIT_BASE, NUM_GRIDS));
        on_len = on_ticks(cfg.duty);
        lit    = (t_pos < on_len) && ({1'b0, slot} < n_act);
    end

    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
        assign grid_o[g] = lit && (slot == IDX_W'(g));
    end

    assign digit_idx_o = slot;
    assign disp_en_o   = lit;

    // R6
    one_grid_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grid_o) && (disp_en_o == (grid_o != '0)));

    // R4
    count_limit_chk: assert property (@(posedge clk) disable iff (rst)
        disp_en_o |-> ({1'b0, digit_idx_o} < n_act));

endmodule

// File: tb/test_grid_scan_top.sv
module test_grid_scan_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 12288;
    localparam int SLOTC      = 512;
    localparam int NV         = 13;

    // {duty[2:0], digits[3:0], slot[4:0], t[5:0]}
    localparam logic [17:0] VEC [NV] = '{
        {3'd0, 4'd0,  5'd0,  6'd0},
        {3'd0, 4'd0,  5'd0,  6'd31},
        {3'd0, 4'd0,  5'd0,  6'd32},
        {3'd0, 4'd0,  5'd23, 6'd10},
        {3'd7, 4'd1,  5'd0,  6'd59},
        {3'd7, 4'd1,  5'd0,  6'd60},
        {3'd7, 4'd1,  5'd8,  6'd5},
        {3'd7, 4'd1,  5'd9,  6'd5},
        {3'd3, 4'd15, 5'd22, 6'd43},
        {3'd3, 4'd15, 5'd22, 6'd44},
        {3'd3, 4'd15, 5'd23, 6'd0},
        {3'd5, 4'd8,  5'd15, 6'd51},
        {3'd5, 4'd8,  5'd16, 6'd0}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        duty_we = 0;
    logic [2:0]  duty_val = 0;
    logic        digits_we = 0;
    logic [3:0]  digits_val = 0;
    logic [23:0] grid_o;
    logic [4:0]  digit_idx_o;
    logic        disp_en_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    grid_scan_top i_grid_scan_top (
        .clk(clk), .rst(rst),
        .duty_we(duty_we), .duty_val(duty_val),
        .digits_we(digits_we), .digits_val(digits_val),
        .grid_o(grid_o), .digit_idx_o(digit_idx_o), .disp_en_o(disp_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic int n_grids(int k);
        return (k == 0) ? 24 : k + 8;
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic wr_duty(int d);
        duty_we = 1; duty_val = 3'(d);
        @(negedge clk);
        duty_we = 0;
    endtask

    task automatic wr_digits(int k);
        digits_we = 1; digits_val = 4'(k);
        @(negedge clk);
        digits_we = 0;
    endtask

    task automatic wait_to(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic check(string req, int slot, bit on);
        logic [23:0] exp_g;
        exp_g = on ? (24'd1 << slot) : 24'd0;
        checks++;
        if (grid_o !== exp_g || disp_en_o !== on || digit_idx_o !== 5'(slot)) begin
            errors++;
            $display("FAIL %s at cyc %0d: grid=%h en=%b idx=%0d expected grid=%h en=%b idx=%0d",
                     req, cyc, grid_o, disp_en_o, digit_idx_o, exp_g, on, slot);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        int cur_d, cur_k, fr, base;
        cur_d = 0; cur_k = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R7: reset state, slot 0 lit at first cycle
        check("R7", 0, 1);
        // R1: 8-cycle tick, 32 T on at code 0
        wait_to(255); check("R1", 0, 1);
        wait_to(256); check("R1", 0, 0);
        // R2: slot boundary at 64 T
        wait_to(511); check("R2", 0, 0);
        wait_to(512); check("R2", 1, 1);
        // R7: default 24 digits
        wait_to(23*SLOTC + 84); check("R7", 23, 1);

        // table walk: R3 / R4
        for (int i = 0; i < NV; i++) begin
            int d, k, s, t, off;
            d = VEC[i][17:15]; k = VEC[i][14:11];
            s = VEC[i][10:6];  t = VEC[i][5:0];
            off = s*SLOTC + t*8 + 4;
            if (d != cur_d || k != cur_k) begin
                wr_duty(d); wr_digits(k);
                cur_d = d; cur_k = k;
                fr = cyc / FRAME + 1;
            end else begin
                fr = cyc / FRAME;
                if (fr*FRAME + off <= cyc) fr++;
            end
            wait_to(fr*FRAME + off);
            check((s >= n_grids(k)) ? "R4" : "R3", s,
                  (s < n_grids(k)) && (t < (8 + d) * 4));
        end

        // R8: mid-frame writes wait for the frame boundary
        fr = cyc / FRAME + 1;
        base = fr * FRAME;
        wait_to(base + 2*SLOTC + 4);
        wr_duty(0); wr_digits(0);
        wait_to(base + 3*SLOTC + 40*8 + 4);  check("R8", 3, 1);
        wait_to(base + 20*SLOTC + 4);        check("R8", 20, 0);
        base = base + FRAME;
        wait_to(base + 3*SLOTC + 40*8 + 4);  check("R8", 3, 0);
        wait_to(base + 20*SLOTC + 4);        check("R8", 20, 1);

        // R5: frame length independent of digit count
        wr_digits(1);
        base = base + FRAME;
        wait_to(base + 8*SLOTC + 4);         check("R4", 8, 1);
        wait_to(base + FRAME - 1);           check("R5", 23, 0);
        wait_to(base + FRAME);               check("R5", 0, 1);

        // R7: reset mid-run discards setting and pending write
        wr_duty(7);
        do_reset();
        check("R7", 0, 1);
        wait_to(40*8 + 4);                   check("R7", 0, 0);
        wait_to(20*SLOTC + 4);               check("R7", 20, 1);

        report();
    end
endmodule